// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar as two-digit BCD fields. It counts hundredths of a second, seconds, minutes, hours (24-hour form), day of week, date, month, year and century. It is driven by a clock enable that pulses once for each period of a 32.768 kHz source. A fractional divider inside the block turns those pulses into exactly one hundred hundredths ticks for every 32768 enables. Each tick is carried up through all the fields in the same cycle. The day count follows the length of the current month, including February in leap years.

Software or a host interface sets the time with a parallel load. Each field has its own mask bit, so fields that are not selected keep their value. Any load, and a separate divider-clear input, restarts the sub-second divider from zero. The next hundredth is therefore a full period away from the moment the time was set. All fields are registered outputs in BCD.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: While rst is high, and after it is released with no enable, the fields read hundredths 00, seconds 00, minutes 00, hours 00, weekday 01, date 01, month 01, year 00 and century 00.
- R2: The divider advances only when tick_32k is high. After a load or a divider clear, the first hundredths advance happens on the 328th enable. Every 32768 enables give exactly 100 advances, spaced 327 or 328 enables apart.
- R3: Hundredths count 00 to 99 and carry into seconds. Seconds and minutes count 00 to 59, and hours count 00 to 23. Each field wraps to 00 and carries into the next field in the same cycle.
- R4: A carry out of hours advances the weekday, which counts 01 to 07 and wraps to 01. The same carry advances the date, which starts at 01.
- R5: The date wraps to 01 after 31 for months 01, 03, 05, 07, 08, 10 and 12, and after 30 for months 04, 06, 09 and 11. For month 02 it wraps after 29 when the year is a multiple of four (year 00 included) and after 28 otherwise.
- R6: A carry out of the date advances the month, which counts 01 to 12. Month 12 wrapping to 01 advances the year. Year 99 wrapping to 00 advances the century, and century 99 wraps to 00.
- R7: When load_en is high, each field whose load_mask bit is set takes its ld_* value at that edge. The mask bits are hsec=0, sec=1, min=2, hour=3, wday=4, date=5, month=6, year=7, century=8. Fields with a clear bit keep their value. No field counts in a load cycle, even if a tick falls on that edge.
- R8: load_en (whatever the mask) and div_clr both reset the divider to zero. div_clr changes no field.
- R9: A field that holds a non-BCD digit, or a value above its maximum, goes to its minimum on its next increment and carries into the next field.
- R10: With tick_32k low, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle enable per 32.768 kHz period |
| div_clr | input | 1 | Restart the sub-second divider |
| load_en | input | 1 | Parallel load strobe |
| load_mask | input | 9 | Per-field load select (bit 0 hundredths ... bit 8 century) |
| ld_hsec | input | 8 | Load value, hundredths (BCD) |
| ld_sec | input | 8 | Load value, seconds |
| ld_min | input | 8 | Load value, minutes |
| ld_hour | input | 8 | Load value, hours |
| ld_wday | input | 8 | Load value, weekday |
| ld_date | input | 8 | Load value, date |
| ld_month | input | 8 | Load value, month |
| ld_year | input | 8 | Load value, year |
| ld_century | input | 8 | Load value, century |
| hsec | output | 8 | Hundredths of a second (BCD) |
| sec | output | 8 | Seconds |
| min | output | 8 | Minutes |
| hour | output | 8 | Hours, 00-23 |
| wday | output | 8 | Day of week, 01-07 |
| date | output | 8 | Day of month |
| month | output | 8 | Month, 01-12 |
| year | output | 8 | Year within century |
| century | output | 8 | Century |

## Verification
The assertions check these rules on every cycle:
- each divider tick comes 327 or 328 enables after the previous tick or restart;
- a loaded field takes its value on the next cycle;
- a field that is neither loaded nor incremented stays unchanged;
- every increment leaves a legal BCD value inside the field's range;
- the weekday and century wrap to their minimums.

Only the bench scenarios can show the rest:
- the exact carry results across month ends, leap and non-leap Februaries, and the year and century rollovers;
- the 328-enable delay after a load or divider clear;
- a load overriding a tick on the same edge;
- the full 32768-enable second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_FIELDS = 9;
  localparam int F_HSEC  = 0;
  localparam int F_SEC   = 1;
  localparam int F_MIN   = 2;
  localparam int F_HOUR  = 3;
  localparam int F_WDAY  = 4;
  localparam int F_DATE  = 5;
  localparam int F_MONTH = 6;
  localparam int F_YEAR  = 7;
  localparam int F_CENT  = 8;

  typedef logic [7:0] bcd2_t;

  function automatic logic bcd_ok(input bcd2_t v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  function automatic bcd2_t bcd_inc(input bcd2_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic bcd2_t field_min(input int idx);
    case (idx)
      F_WDAY, F_DATE, F_MONTH: return 8'h01;
      default:                 return 8'h00;
    endcase
  endfunction

  // maximum of fields with a fixed range (date gets its limit at run time)
  function automatic bcd2_t field_max(input int idx);
    case (idx)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR:       return 8'h23;
      F_WDAY:       return 8'h07;
      F_DATE:       return 8'h31;
      F_MONTH:      return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction
endpackage

// File: rtl/rtc_frac_div.sv
module rtc_frac_div #(
  parameter int SRC_HZ  = 32768,
  parameter int TICK_HZ = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int AW = $clog2(SRC_HZ);
  localparam logic [AW:0] MODV = (AW+1)'(SRC_HZ);
  localparam logic [AW:0] STEP = (AW+1)'(TICK_HZ);
  localparam int GAP_LO = SRC_HZ / TICK_HZ;

  logic [AW-1:0] acc;
  logic [AW:0]   sum;

  always_comb begin
    sum  = {1'b0, acc} + STEP;
    tick = en && !clr && (sum >= MODV);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  acc <= '0;
    else if (tick)   acc <= AW'(sum - MODV);
    else if (en)     acc <= sum[AW-1:0];
  end

  // enable count since the last tick or restart, for the spacing check
  logic [AW:0] gap;
  always_ff @(posedge clk) begin
    if (rst || clr || tick) gap <= '0;
    else if (en)            gap <= gap + 1'b1;
  end

  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap == (AW+1)'(GAP_LO - 1)) || (gap == (AW+1)'(GAP_LO)));
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
  input  logic [7:0] month,
  input  logic [7:0] year,
  output logic [7:0] last_day
);
  logic leap;
  always_comb begin
    // multiple of four in BCD: even tens with units 0/4/8, odd tens with 2/6
    if (year[4] == 1'b0)
      leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) || (year[3:0] == 4'd8);
    else
      leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
    case (month)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter logic [7:0] MINV = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc,
  input  logic [7:0] max_bcd,
  input  logic       ld,
  input  logic [7:0] ld_val,
  output logic [7:0] val,
  output logic       at_end
);
  // an illegal or out-of-range value counts as the end of range
  always_comb at_end = !bcd_ok(val) || (val >= max_bcd);

  always_ff @(posedge clk) begin
    if (rst)      val <= MINV;
    else if (ld)  val <= ld_val;
    else if (inc) val <= at_end ? MINV : bcd_inc(val);
  end

  p_load_takes_r7: assert property (@(posedge clk) disable iff (rst)
    ld |=> val == $past(ld_val));
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!ld && !inc) |=> $stable(val));
  p_inc_legal_r9: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld) |=> bcd_ok(val) && (val >= MINV) && (val <= $past(max_bcd)));
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_pkg::*;
#(
  parameter int SRC_HZ  = 32768,
  parameter int TICK_HZ = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_32k,
  input  logic       div_clr,
  input  logic       load_en,
  input  logic [8:0] load_mask,
  input  logic [7:0] ld_hsec,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_wday,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  input  logic [7:0] ld_century,
  output logic [7:0] hsec,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] wday,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic [7:0] century
);
  localparam int NF = NUM_FIELDS;

  logic             tick;
  logic [7:0]       ldv  [NF];
  logic [7:0]       fval [NF];
  logic [7:0]       fmax [NF];
  logic [NF-1:0]    inc;
  logic [NF-1:0]    wrap;
  logic             day_carry;
  logic [7:0]       mlen;

  rtc_frac_div #(.SRC_HZ(SRC_HZ), .TICK_HZ(TICK_HZ)) u_div (
    .clk(clk), .rst(rst), .en(tick_32k), .clr(div_clr || load_en), .tick(tick)
  );

  rtc_month_len u_mlen (
    .month(fval[F_MONTH]), .year(fval[F_YEAR]), .last_day(mlen)
  );

  always_comb begin
    ldv[F_HSEC]  = ld_hsec;
    ldv[F_SEC]   = ld_sec;
    ldv[F_MIN]   = ld_min;
    ldv[F_HOUR]  = ld_hour;
    ldv[F_WDAY]  = ld_wday;
    ldv[F_DATE]  = ld_date;
    ldv[F_MONTH] = ld_month;
    ldv[F_YEAR]  = ld_year;
    ldv[F_CENT]  = ld_century;
  end

  // ripple carry: time fields in series, then weekday and date in parallel
  always_comb begin
    inc[F_HSEC]  = tick;
    inc[F_SEC]   = inc[F_HSEC] & wrap[F_HSEC];
    inc[F_MIN]   = inc[F_SEC]  & wrap[F_SEC];
    inc[F_HOUR]  = inc[F_MIN]  & wrap[F_MIN];
    day_carry    = inc[F_HOUR] & wrap[F_HOUR];
    inc[F_WDAY]  = day_carry;
    inc[F_DATE]  = day_carry;
    inc[F_MONTH] = day_carry & wrap[F_DATE];
    inc[F_YEAR]  = inc[F_MONTH] & wrap[F_MONTH];
    inc[F_CENT]  = inc[F_YEAR]  & wrap[F_YEAR];
  end

  for (genvar i = 0; i < NF; i++) begin : g_field
    localparam logic [7:0] FMIN = field_min(i);
    if (i == F_DATE) begin : g_dyn
      always_comb fmax[i] = mlen;
    end else begin : g_fix
      always_comb fmax[i] = field_max(i);
    end
    rtc_bcd_field #(.MINV(FMIN)) u_fld (
      .clk(clk), .rst(rst), .inc(inc[i]), .max_bcd(fmax[i]),
      .ld(load_en && load_mask[i]), .ld_val(ldv[i]),
      .val(fval[i]), .at_end(wrap[i])
    );
  end

  always_comb begin
    hsec    = fval[F_HSEC];
    sec     = fval[F_SEC];
    min     = fval[F_MIN];
    hour    = fval[F_HOUR];
    wday    = fval[F_WDAY];
    date    = fval[F_DATE];
    month   = fval[F_MONTH];
    year    = fval[F_YEAR];
    century = fval[F_CENT];
  end

  p_wday_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (day_carry && wrap[F_WDAY] && !(load_en && load_mask[F_WDAY])) |=> wday == 8'h01);
  p_cent_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (inc[F_CENT] && wrap[F_CENT] && !(load_en && load_mask[F_CENT])) |=> century == 8'h00);
  p_no_count_on_load_r7: assert property (@(posedge clk) disable iff (rst)
    (load_en && !load_mask[F_HSEC]) |=> $stable(hsec));
  p_quiet_enable_r10: assert property (@(posedge clk) disable iff (rst)
    (!tick_32k && !load_en) |=> $stable(hsec));
endmodule

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_32k = 1'b1;
  logic div_clr = 1'b0;
  logic load_en = 1'b0;
  logic [8:0] load_mask = '0;
  logic [71:0] ldbus = '0;
  logic [7:0] hsec, sec, min, hour, wday, date, month, year, century;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  rtc_bcd_calendar u_dut (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .div_clr(div_clr),
    .load_en(load_en), .load_mask(load_mask),
    .ld_hsec(ldbus[7:0]), .ld_sec(ldbus[15:8]), .ld_min(ldbus[23:16]),
    .ld_hour(ldbus[31:24]), .ld_wday(ldbus[39:32]), .ld_date(ldbus[47:40]),
    .ld_month(ldbus[55:48]), .ld_year(ldbus[63:56]), .ld_century(ldbus[71:64]),
    .hsec(hsec), .sec(sec), .min(min), .hour(hour), .wday(wday), .date(date),
    .month(month), .year(year), .century(century)
  );

  // order: century year month date wday hour min sec hsec
  function automatic logic [71:0] now();
    return {century, year, month, date, wday, hour, min, sec, hsec};
  endfunction

  task automatic chk(input string req, input logic [71:0] exp);
    checks++;
    if (now() !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, now(), exp);
    end
  endtask

  task automatic do_load(input logic [71:0] v, input logic [8:0] m);
    @(negedge clk);
    ldbus = v; load_mask = m; load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  localparam int NV = 14;
  localparam logic [143:0] VEC [NV] = '{
    {72'h20_24_01_01_01_00_00_00_00, 72'h20_24_01_01_01_00_00_00_01}, // R3
    {72'h20_24_06_15_03_12_34_56_99, 72'h20_24_06_15_03_12_34_57_00}, // R3
    {72'h20_24_06_15_03_12_59_59_99, 72'h20_24_06_15_03_13_00_00_00}, // R3
    {72'h20_99_12_31_07_23_59_59_99, 72'h21_00_01_01_01_00_00_00_00}, // R6 R4
    {72'h20_24_02_28_03_23_59_59_99, 72'h20_24_02_29_04_00_00_00_00}, // R5 leap
    {72'h20_24_02_29_04_23_59_59_99, 72'h20_24_03_01_05_00_00_00_00}, // R5
    {72'h20_23_02_28_02_23_59_59_99, 72'h20_23_03_01_03_00_00_00_00}, // R5
    {72'h20_23_04_30_06_23_59_59_99, 72'h20_23_05_01_07_00_00_00_00}, // R5
    {72'h20_23_01_30_05_23_59_59_99, 72'h20_23_01_31_06_00_00_00_00}, // R5
    {72'h99_99_12_31_07_23_59_59_99, 72'h00_00_01_01_01_00_00_00_00}, // R6
    {72'h20_00_02_28_02_23_59_59_99, 72'h20_00_02_29_03_00_00_00_00}, // R5 year 00
    {72'h20_24_06_15_03_12_34_6A_99, 72'h20_24_06_15_03_12_35_00_00}, // R9
    {72'h20_24_06_15_03_12_34_56_9F, 72'h20_24_06_15_03_12_34_57_00}, // R9
    {72'h20_24_06_15_03_24_59_59_99, 72'h20_24_06_16_04_00_00_00_00}  // R9
  };
  localparam int VREQ [NV] = '{3, 3, 3, 6, 5, 5, 5, 5, 5, 6, 5, 9, 9, 9};

  localparam logic [71:0] BASE = 72'h20_24_06_15_03_12_34_56_00;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", 72'h00_00_01_01_01_00_00_00_00);
    rst = 1'b0;
    tick_32k = 1'b0;
    edges(5);
    chk("R1 after release", 72'h00_00_01_01_01_00_00_00_00);
    tick_32k = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i][143:72], 9'h1FF);
      edges(327);
      chk($sformatf("R2 no early advance vec %0d", i), VEC[i][143:72]);
      edges(1);
      chk($sformatf("R%0d vec %0d", VREQ[i], i), VEC[i][71:0]);
    end

    // R7: masked load on the edge where a tick falls
    do_load(BASE, 9'h1FF);
    edges(326);
    @(negedge clk);
    ldbus = 72'h11_11_11_11_11_11_45_11_11; load_mask = 9'h004; load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    chk("R7 masked load overrides tick", 72'h20_24_06_15_03_12_45_56_00);
    edges(327);
    chk("R8 load restarts divider", 72'h20_24_06_15_03_12_45_56_00);
    edges(1);
    chk("R8 first tick after load", 72'h20_24_06_15_03_12_45_56_01);

    // R8: divider clear only
    do_load(BASE, 9'h1FF);
    edges(200);
    div_clr = 1'b1;
    @(negedge clk);
    div_clr = 1'b0;
    chk("R8 clear keeps fields", BASE);
    edges(327);
    chk("R8 no tick before 328 after clear", BASE);
    edges(1);
    chk("R8 tick 328 after clear", 72'h20_24_06_15_03_12_34_56_01);

    // R10: enable low freezes everything
    do_load(BASE, 9'h1FF);
    tick_32k = 1'b0;
    edges(1000);
    chk("R10 frozen without enable", BASE);
    tick_32k = 1'b1;
    edges(327);
    chk("R10 resumes count", BASE);
    edges(1);
    chk("R10 first tick after resume", 72'h20_24_06_15_03_12_34_56_01);

    // R2: one full second is 32768 enables
    do_load(72'h20_24_06_15_03_12_34_00_00, 9'h1FF);
    edges(32767);
    chk("R2 99 hundredths before second", 72'h20_24_06_15_03_12_34_00_99);
    edges(1);
    chk("R2 second after 32768 enables", 72'h20_24_06_15_03_12_34_01_00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule